// File: doc/BRIEF.md
# Device Self-Test Request Controller

This block is the software-facing control point for sending a built-in self-test frame from a multi-port serial storage controller to the attached device. Software writes one 32-bit register that holds a trigger bit for each port, a shared six-bit test parameter field and two sticky completion flags. The block finds the 0-to-1 transitions of the trigger bits and checks each requesting port against its device-present and low-power inputs and against its own lockout state. It then hands at most one request at a time to the link layer as a one-cycle strobe with a port number and a pattern byte.

The link layer returns a single completion pulse tagged OK or ERR. The block records the result in the success or failure flag. After a success it locks the port until software cycles that port's enable off and on. After a failure, software can retry by clearing and then setting the trigger bit again. The number of implemented ports is a parameter from 1 to 8. Trigger bits of ports above that number read as zero and have no effect.

Top module: `selftest_req_ctrl`

## Requirements
- R1: Register read layout: trigger bits for ports 0 and 1 at bits 8 and 9, trigger bits for ports 2 to 7 at bits 12 to 17, success flag at bit 11, failure flag at bit 10, parameter field at bits 7:2. Bits 31:18 and 1:0 always read 0. All bits read 0 after reset.
- R2: A request is considered only in the write that moves a port's trigger bit from 0 to 1. Writing the bit as 1 again does not launch a request. When a request is launched, `req_valid` is high for exactly one cycle, on the second rising clock edge counted from the edge that takes the write.
- R3: A rising trigger is dropped if, in the cycle after the write, the port has no device present or is in a low-power (partial or slumber) state.
- R4: A completion with `cpl_err`=0 sets the success flag (bit 11). A completion with `cpl_err`=1 sets the failure flag (bit 10). The other flag is left as it is. A completion that arrives when no request is outstanding is ignored.
- R5: Writing 1 to bit 11 or bit 10 clears that flag, and writing 0 leaves it unchanged. If a completion sets a flag in the same cycle that a write clears it, the flag ends up set.
- R6: After an OK completion on a port, triggers on that port are dropped until the port's enable has been seen low and then high again.
- R7: After an ERR completion, writing the port's trigger bit to 0 and then to 1 launches a new request with no enable toggle.
- R8: `req_pattern` equals the parameter field in bits 7:2 with bits 1:0 zero, and the same field is used for every port.
- R9: Trigger bits of ports numbered NPORTS and above read as 0 and never cause a request.
- R10: Only one request is outstanding at a time. A rising trigger that arrives before the outstanding request's completion has been taken is dropped, not queued.
- R11: When several eligible trigger bits rise in one write, only the lowest-numbered eligible port is served and the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| port_present | input | NPORTS | Device present, one bit per port |
| port_lowpwr | input | NPORTS | Port is in partial or slumber state |
| port_enable | input | NPORTS | Port enable, one bit per port |
| req_valid | output | 1 | One-cycle self-test request strobe |
| req_port | output | 3 | Target port of the request |
| req_pattern | output | 8 | Pattern byte for the request |
| cpl_valid | input | 1 | Completion pulse from the link layer |
| cpl_err | input | 1 | Completion status: 0 OK, 1 ERR |

## Verification
The bench holds trigger bits at 1 and rewrites them to show that a level-sensitive design would launch requests again and again. It retries a port after an ERR completion but refuses it after an OK completion until the enable toggles, which catches a design that locks on both outcomes or never unlocks. It raises several triggers together while one of them is gated, which exposes priority or gating errors. It also raises a trigger while a request is busy and then completes that request, so a design that queues the dropped edge would issue a late request. It drives a completion in the same cycle as a write-one-to-clear, so a design where the clear wins loses the flag. It also writes the bits of unimplemented ports and the reserved bits, which a design that stores them would read back as ones.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    localparam int MAX_PORTS = 8;
    localparam int PORT_W    = 3;
    localparam int PARAM_W   = 6;
    localparam int OK_BIT    = 11;
    localparam int ERR_BIT   = 10;
    localparam int PARAM_LSB = 2;

    typedef logic [MAX_PORTS-1:0] port_vec_t;
    typedef logic [PARAM_W-1:0]   param_t;

    // Register bit that carries the trigger of a given port.
    function automatic int trig_pos(input int port);
        return (port < 2) ? (8 + port) : (10 + port);
    endfunction

endpackage

// File: rtl/selftest_trig_regs.sv
module selftest_trig_regs
    import selftest_pkg::*;
#(
    parameter int NPORTS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output port_vec_t   trig_o,
    output port_vec_t   rise_o,
    output param_t      param_o
);

    typedef struct packed {
        port_vec_t trig;
        port_vec_t rise;
        param_t    param;
    } trig_st_t;

    trig_st_t  st_d, st_q;
    port_vec_t wr_trig;

    always_comb begin
        wr_trig = '0;
        for (int i = 0; i < MAX_PORTS; i++) begin
            if (i < NPORTS) begin
                wr_trig[i] = wr_data_i[trig_pos(i)];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.rise = '0;
        if (wr_en_i) begin
            st_d.trig  = wr_trig;
            st_d.rise  = wr_trig & ~st_q.trig;
            st_d.param = wr_data_i[PARAM_LSB +: PARAM_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o  = st_q.trig;
    assign rise_o  = st_q.rise;
    assign param_o = st_q.param;

    // R2: an edge marker only follows a register write
    p_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rise != '0) |-> $past(wr_en_i));

endmodule

// File: rtl/selftest_lock.sv
module selftest_lock
    import selftest_pkg::*;
#(
    parameter int NPORTS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid_i,
    input  logic [PORT_W-1:0] set_port_i,
    input  port_vec_t         enable_i,
    output port_vec_t         lock_o
);

    typedef struct packed {
        port_vec_t locked;
        port_vec_t off_seen;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MAX_PORTS; i++) begin
            if (i < NPORTS) begin
                if (st_q.locked[i] && !enable_i[i]) begin
                    st_d.off_seen[i] = 1'b1;
                end
                if (st_q.locked[i] && st_q.off_seen[i] && enable_i[i]) begin
                    st_d.locked[i]   = 1'b0;
                    st_d.off_seen[i] = 1'b0;
                end
                if (set_valid_i && (set_port_i == PORT_W'(i))) begin
                    st_d.locked[i]   = 1'b1;
                    st_d.off_seen[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.locked;

    // R6: a success locks the port that completed
    p_lock_on_success_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid_i |=> st_q.locked[$past(set_port_i)]);

endmodule

// File: rtl/selftest_issue.sv
module selftest_issue
    import selftest_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  port_vec_t         rise_i,
    input  port_vec_t         present_i,
    input  port_vec_t         lowpwr_i,
    input  port_vec_t         lock_i,
    input  param_t            param_i,
    input  logic              clr_ok_i,
    input  logic              clr_err_i,
    input  logic              cpl_valid_i,
    input  logic              cpl_err_i,
    output logic              req_valid_o,
    output logic [PORT_W-1:0] req_port_o,
    output logic [7:0]        req_pattern_o,
    output logic              ok_o,
    output logic              err_o,
    output logic              done_ok_o,
    output logic [PORT_W-1:0] done_port_o
);

    typedef struct packed {
        logic              req_valid;
        logic [PORT_W-1:0] port;
        logic [7:0]        pattern;
        logic              busy;
        logic              ok;
        logic              err;
    } issue_st_t;

    issue_st_t         st_d, st_q;
    port_vec_t         elig;
    logic [PORT_W-1:0] sel;
    logic              found;
    logic              done_ok, done_err;

    always_comb begin
        elig  = rise_i & present_i & ~lowpwr_i & ~lock_i;
        sel   = '0;
        found = 1'b0;
        for (int i = MAX_PORTS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                sel   = PORT_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        done_ok  = cpl_valid_i && st_q.busy && !cpl_err_i;
        done_err = cpl_valid_i && st_q.busy && cpl_err_i;

        st_d           = st_q;
        st_d.req_valid = 1'b0;
        if (cpl_valid_i && st_q.busy) begin
            st_d.busy = 1'b0;
        end
        if (!st_q.busy && found) begin
            st_d.req_valid = 1'b1;
            st_d.busy      = 1'b1;
            st_d.port      = sel;
            st_d.pattern   = {param_i, 2'b00};
        end
        st_d.ok  = (st_q.ok  && !clr_ok_i)  || done_ok;
        st_d.err = (st_q.err && !clr_err_i) || done_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid_o   = st_q.req_valid;
    assign req_port_o    = st_q.port;
    assign req_pattern_o = st_q.pattern;
    assign ok_o          = st_q.ok;
    assign err_o         = st_q.err;
    assign done_ok_o     = done_ok;
    assign done_port_o   = st_q.port;

    // R10: the strobe never lasts two cycles, since the block is then busy
    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req_valid |=> !st_q.req_valid);

    // R3: an issued port was present, awake and not locked when chosen
    p_gated_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req_valid |->
            ((($past(present_i & ~lowpwr_i & ~lock_i)) >> st_q.port) & 8'd1) == 8'd1);

    // R4: an OK completion on a busy block raises the success flag
    p_ok_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid_i && st_q.busy && !cpl_err_i) |=> st_q.ok);

    // R4: an ERR completion on a busy block raises the failure flag
    p_err_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid_i && st_q.busy && cpl_err_i) |=> st_q.err);

endmodule

// File: rtl/selftest_req_ctrl.sv
module selftest_req_ctrl
    import selftest_pkg::*;
#(
    parameter int NPORTS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    input  logic [NPORTS-1:0] port_present,
    input  logic [NPORTS-1:0] port_lowpwr,
    input  logic [NPORTS-1:0] port_enable,
    output logic              req_valid,
    output logic [2:0]        req_port,
    output logic [7:0]        req_pattern,
    input  logic              cpl_valid,
    input  logic              cpl_err
);

    port_vec_t         trig, rise, lock, present8, lowpwr8, enable8;
    param_t            param;
    logic              ok_flag, err_flag, done_ok;
    logic [PORT_W-1:0] done_port;

    always_comb begin
        present8 = '0;
        lowpwr8  = '0;
        enable8  = '0;
        present8[NPORTS-1:0] = port_present;
        lowpwr8[NPORTS-1:0]  = port_lowpwr;
        enable8[NPORTS-1:0]  = port_enable;
    end

    selftest_trig_regs #(.NPORTS(NPORTS)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .wr_data_i (reg_wr_data),
        .trig_o    (trig),
        .rise_o    (rise),
        .param_o   (param)
    );

    selftest_lock #(.NPORTS(NPORTS)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_valid_i (done_ok),
        .set_port_i  (done_port),
        .enable_i    (enable8),
        .lock_o      (lock)
    );

    selftest_issue u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise_i        (rise),
        .present_i     (present8),
        .lowpwr_i      (lowpwr8),
        .lock_i        (lock),
        .param_i       (param),
        .clr_ok_i      (reg_wr_en && reg_wr_data[OK_BIT]),
        .clr_err_i     (reg_wr_en && reg_wr_data[ERR_BIT]),
        .cpl_valid_i   (cpl_valid),
        .cpl_err_i     (cpl_err),
        .req_valid_o   (req_valid),
        .req_port_o    (req_port),
        .req_pattern_o (req_pattern),
        .ok_o          (ok_flag),
        .err_o         (err_flag),
        .done_ok_o     (done_ok),
        .done_port_o   (done_port)
    );

    always_comb begin
        reg_rd_data = '0;
        for (int i = 0; i < MAX_PORTS; i++) begin
            reg_rd_data[trig_pos(i)] = trig[i];
        end
        reg_rd_data[OK_BIT]                  = ok_flag;
        reg_rd_data[ERR_BIT]                 = err_flag;
        reg_rd_data[PARAM_LSB +: PARAM_W]    = param;
    end

endmodule

// File: tb/selftest_req_ctrl_test.sv
module selftest_req_ctrl_test;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [31:0]   reg_wr_data = '0;
    logic [31:0]   reg_rd_data;
    logic [NP-1:0] port_present = '1;
    logic [NP-1:0] port_lowpwr = '0;
    logic [NP-1:0] port_enable = '1;
    logic          req_valid;
    logic [2:0]    req_port;
    logic [7:0]    req_pattern;
    logic          cpl_valid = 1'b0;
    logic          cpl_err = 1'b0;

    int total = 0;
    int fails = 0;
    logic [7:0] sw_trig = '0;
    logic [5:0] sw_param = 6'b101011;

    always #2.5 clk = ~clk;

    selftest_req_ctrl #(.NPORTS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .port_present(port_present), .port_lowpwr(port_lowpwr),
        .port_enable(port_enable), .req_valid(req_valid), .req_port(req_port),
        .req_pattern(req_pattern), .cpl_valid(cpl_valid), .cpl_err(cpl_err)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Trigger layout: ports 0,1 at bits 8,9; ports 2..7 at bits 12..17.
    function automatic logic [31:0] build(input logic [7:0] t, input logic [5:0] prm,
                                          input logic c_ok, input logic c_err);
        logic [31:0] d = '0;
        d[9:8]   = t[1:0];
        d[17:12] = t[7:2];
        d[7:2]   = prm;
        d[11]    = c_ok;
        d[10]    = c_err;
        return d;
    endfunction

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic set_trig(input int p, input logic v);
        sw_trig[p] = v;
        reg_write(build(sw_trig, sw_param, 1'b0, 1'b0));
    endtask

    task automatic expect_req(input string rq, input logic exp, input int port);
        @(negedge clk);
        chk(rq, "req_valid", 32'(req_valid), 32'(exp));
        if (exp) begin
            chk(rq, "req_port", 32'(req_port), 32'(port));
            chk("R8", "req_pattern", 32'(req_pattern), 32'({sw_param, 2'b00}));
        end
    endtask

    task automatic complete(input logic err);
        @(negedge clk);
        cpl_valid = 1'b1;
        cpl_err   = err;
        @(negedge clk);
        cpl_valid = 1'b0;
        cpl_err   = 1'b0;
    endtask

    task automatic clear_flags();
        reg_write(build(sw_trig, sw_param, 1'b1, 1'b1));
    endtask

    task automatic t_reset();
        chk("R1", "reset readback", reg_rd_data, 32'h0);
        chk("R2", "reset req_valid", 32'(req_valid), 32'h0);
    endtask

    task automatic t_basic();
        set_trig(0, 1'b1);
        expect_req("R2", 1'b1, 0);
        @(negedge clk);
        chk("R2", "strobe one cycle", 32'(req_valid), 32'h0);
        reg_write(build(sw_trig, sw_param, 1'b0, 1'b0));
        expect_req("R2", 1'b0, 0);
        complete(1'b0);
        chk("R4", "ok flag", 32'(reg_rd_data[11]), 32'h1);
        chk("R4", "err flag untouched", 32'(reg_rd_data[10]), 32'h0);
        chk("R1", "readback layout", reg_rd_data, build(sw_trig, sw_param, 1'b1, 1'b0));
        reg_write(build(sw_trig, sw_param, 1'b0, 1'b0));
        chk("R5", "write 0 keeps flag", 32'(reg_rd_data[11]), 32'h1);
        clear_flags();
        chk("R5", "w1c clears", reg_rd_data, build(sw_trig, sw_param, 1'b0, 1'b0));
    endtask

    task automatic t_lockout();
        set_trig(0, 1'b0);
        set_trig(0, 1'b1);
        expect_req("R6", 1'b0, 0);
        @(negedge clk);
        port_enable[0] = 1'b0;
        repeat (2) @(negedge clk);
        port_enable[0] = 1'b1;
        repeat (2) @(negedge clk);
        set_trig(0, 1'b0);
        set_trig(0, 1'b1);
        expect_req("R6", 1'b1, 0);
        complete(1'b1);
        chk("R4", "err flag", 32'(reg_rd_data[10]), 32'h1);
        chk("R4", "ok flag untouched", 32'(reg_rd_data[11]), 32'h0);
    endtask

    task automatic t_retry();
        set_trig(0, 1'b0);
        expect_req("R7", 1'b0, 0);
        set_trig(0, 1'b1);
        expect_req("R7", 1'b1, 0);
        complete(1'b0);
        clear_flags();
    endtask

    task automatic t_gating();
        sw_param = 6'b010110;
        port_present[1] = 1'b0;
        set_trig(1, 1'b1);
        expect_req("R3", 1'b0, 1);
        port_lowpwr[2] = 1'b1;
        set_trig(2, 1'b1);
        expect_req("R3", 1'b0, 2);
        set_trig(3, 1'b1);
        expect_req("R3", 1'b1, 3);
        complete(1'b1);
        port_present[1] = 1'b1;
        clear_flags();
    endtask

    task automatic t_priority();
        sw_trig = '0;
        reg_write(build(sw_trig, sw_param, 1'b0, 1'b0));
        sw_trig[2] = 1'b1;
        sw_trig[4] = 1'b1;
        sw_trig[5] = 1'b1;
        reg_write(build(sw_trig, sw_param, 1'b0, 1'b0));
        expect_req("R11", 1'b1, 4);
        port_lowpwr[2] = 1'b0;
    endtask

    task automatic t_busy_drop();
        set_trig(5, 1'b0);
        set_trig(5, 1'b1);
        expect_req("R10", 1'b0, 5);
        complete(1'b0);
        @(negedge clk);
        chk("R10", "no queued request", 32'(req_valid), 32'h0);
        @(negedge clk);
        chk("R10", "no queued request later", 32'(req_valid), 32'h0);
        complete(1'b1);
        chk("R4", "stray completion ignored", 32'(reg_rd_data[10]), 32'h0);
        clear_flags();
    endtask

    task automatic t_set_wins();
        set_trig(5, 1'b0);
        set_trig(5, 1'b1);
        expect_req("R5", 1'b1, 5);
        @(negedge clk);
        cpl_valid   = 1'b1;
        cpl_err     = 1'b0;
        reg_wr_en   = 1'b1;
        reg_wr_data = build(sw_trig, sw_param, 1'b1, 1'b0);
        @(negedge clk);
        cpl_valid   = 1'b0;
        reg_wr_en   = 1'b0;
        chk("R5", "set beats clear", 32'(reg_rd_data[11]), 32'h1);
        clear_flags();
        chk("R5", "cleared after", 32'(reg_rd_data[11]), 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        sw_trig = '0;
        reg_write(build(sw_trig, sw_param, 1'b0, 1'b0));
        d = build(8'b1100_0000, sw_param, 1'b0, 1'b0) | 32'hFFFC_0003;
        reg_write(d);
        expect_req("R9", 1'b0, 6);
        chk("R9", "unimplemented and reserved read 0", reg_rd_data,
            build(8'h00, sw_param, 1'b0, 1'b0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lockout();
        t_retry();
        t_gating();
        t_priority();
        t_busy_drop();
        t_set_wins();
        t_unimpl();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule